// File: doc/BRIEF.md
# RV32IM Single-Cycle Control Decoder

This block is the purely combinational instruction decoder of a single-cycle RV32IM core. It takes one 32-bit instruction word and returns a packed 32-bit control word. That word steers the next-PC source, the two ALU operand multiplexers, the ALU and multiply/divide function codes, the execute-result and writeback multiplexers, and the data-memory request. Alongside the word it drives two register-read port enables and a destination register address that is already qualified by the write enable.

Integration is simple: the fetched instruction goes in and the control word fans out to the datapath in the same cycle. The branch comparison itself is not done here. The word only names the branch test, and the next-PC logic combines that test with the comparison result. Any encoding the block does not recognise produces an all-zero word, so such an instruction changes no architectural state. The parameter `M_EN` removes the multiply/divide group; when it is 0, that group decodes as unrecognised.

Top module: `rv32_ctrl_decoder`

## Requirements
- R1: The layout of ctrl_o, from MSB to LSB, is: pc_sel[31:30] (0 sequential PC+4, 1 branch target, 2 jump, 3 register jump); valid[29]; jump_en[28]; br_sel[27:25] (0 none, 1 eq, 2 ne, 3 lt, 4 ge, 5 ltu, 6 geu); op0_sel[24:22] (0 reg, 1 PC, 2 PC+4, 3 zero, 7 don't-care); op1_sel[21:19] (0 reg, 1 shamt, 2 U-imm, 3 B-imm, 4 I-imm, 5 S-imm, 6 zero, 7 don't-care); alu_fn[18:15] (0 add, 1 sub, 2 sll, 3 slt, 4 sltu, 5 xor, 6 srl, 7 sra, 8 or, 9 and); md_fn[14:12] (0 mul signed x signed, 1 signed x unsigned, 2 unsigned x unsigned, 3 div signed, 4 div unsigned); md_en[11]; md_hi[10]; ex_sel[9:8] (0 ALU, 1 MD, 2 don't-care); mem_op[7:6] (0 none, 1 load, 2 store); mem_w[5:4] (0 byte, 1 half, 2 word); mem_uns[3]; wb_sel[2:1] (0 ALU, 1 memory, 2 don't-care); rf_wen[0]. Every field that a class does not name below is 0, and every legal instruction sets valid.
- R2: An opcode outside LUI 0x37, AUIPC 0x17, JAL 0x6F, JALR 0x67, BRANCH 0x63, LOAD 0x03, STORE 0x23, OP-IMM 0x13 and OP 0x33 produces ctrl_o = 0, rs1_en_o = rs2_en_o = 0 and rf_waddr_o = 0. The same applies to any reserved funct3/funct7 combination inside those opcodes.
- R3: For an OP-IMM that is not a shift: op0 = reg, op1 = I-imm, alu_fn taken from funct3 (0 add, 2 slt, 3 sltu, 4 xor, 6 or, 7 and), rf_wen = 1, and only rs1 is enabled. Bit 30 has no effect.
- R4: Immediate shifts (funct3 1 with funct7 0x00, funct3 5 with funct7 0x00 or 0x20) use op1 = shamt and alu_fn sll, srl or sra, rf_wen = 1, and only rs1 is enabled. Every other funct7 is reserved.
- R5: OP with funct7 0x00 (any funct3), or with funct7 0x20 and funct3 0 or 5, reads both registers with op0 = op1 = reg, writes rd, and selects sub or sra when funct7 is 0x20.
- R6: LUI uses op0 = zero, op1 = U-imm, add. AUIPC uses op0 = PC, op1 = U-imm, add. Both write rd and enable no read port.
- R7: Loads (funct3 0, 1, 2, 4, 5) use op0 = reg, op1 = I-imm, add, mem_op = load, mem_w = funct3[1:0], mem_uns = funct3[2], wb_sel = memory, rf_wen = 1, rs1 only.
- R8: Stores (funct3 0, 1, 2) use op0 = reg, op1 = S-imm, add, mem_op = store, mem_w = funct3[1:0], wb_sel = don't-care, rf_wen = 0, and both read ports enabled.
- R9: JAL sets pc_sel = 2, jump_en, op0 = PC+4, op1 = zero, add, rf_wen = 1, and enables no read port.
- R10: JALR (funct3 0 only) sets pc_sel = 3, jump_en, op0 = PC+4, op1 = zero, add, rf_wen = 1, and enables rs1 only.
- R11: Branches (funct3 other than 2 and 3) set pc_sel = 1 and jump_en = 0, encode the test in br_sel, and use op0 = op1 = reg with alu_fn xor for eq/ne, slt for lt/ge and sltu for ltu/geu. They also set ex_sel = don't-care, wb_sel = don't-care, rf_wen = 0, mem_op = none, and enable both read ports.
- R12: When M_EN = 1, OP with funct7 0x01 reads both registers with op0 = op1 = reg, sets md_en = 1, ex_sel = MD, wb_sel = ALU and rf_wen = 1. The function map is: MUL md_fn 0/md_hi 0, MULH 0/1, MULHSU 1/1, MULHU 2/1, DIV 3/0, DIVU 4/0, REM 3/1, REMU 4/1.
- R13: rf_waddr_o equals instruction bits [11:7] when rf_wen is 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| inst_i | input | 32 | Instruction word to decode |
| ctrl_o | output | 32 | Packed control word, layout in R1 |
| rs1_en_o | output | 1 | First register read port in use |
| rs2_en_o | output | 1 | Second register read port in use |
| rf_waddr_o | output | 5 | Destination register, zero when no write |

## Verification
The embedded assertions re-check, on every evaluation, the relations between fields that separate pieces of logic drive. An invalid word must be all zero with both ports idle. md_en and the MD execute select must agree. Stores must never write the register file. Branches must hold the branch PC source with no memory or writeback activity. Jumps must link through PC+4. A zero write enable must come with a zero write address. Only the bench's reference model can show that each field carries the exact code for every opcode/funct combination. The same holds for rejecting reserved funct7 and funct3 patterns and for leaving ignored bits such as bit 30 of an immediate add without effect.

// File: rtl/rvdec_pkg.sv
package rvdec_pkg;

  localparam int ILEN  = 32;
  localparam int RA_W  = 5;
  localparam int OPC_W = 7;
  localparam int F3_W  = 3;
  localparam int F7_W  = 7;

  localparam logic [OPC_W-1:0] OPC_LUI    = 7'h37;
  localparam logic [OPC_W-1:0] OPC_AUIPC  = 7'h17;
  localparam logic [OPC_W-1:0] OPC_JAL    = 7'h6f;
  localparam logic [OPC_W-1:0] OPC_JALR   = 7'h67;
  localparam logic [OPC_W-1:0] OPC_BRANCH = 7'h63;
  localparam logic [OPC_W-1:0] OPC_LOAD   = 7'h03;
  localparam logic [OPC_W-1:0] OPC_STORE  = 7'h23;
  localparam logic [OPC_W-1:0] OPC_OPIMM  = 7'h13;
  localparam logic [OPC_W-1:0] OPC_OP     = 7'h33;

  localparam logic [F7_W-1:0] F7_BASE = 7'h00;
  localparam logic [F7_W-1:0] F7_ALT  = 7'h20;
  localparam logic [F7_W-1:0] F7_MD   = 7'h01;

  typedef enum logic [3:0] {
    CL_ILL, CL_LUI, CL_AUIPC, CL_JAL, CL_JALR, CL_BR,
    CL_LD, CL_ST, CL_OPI, CL_SHI, CL_OP, CL_MD
  } inst_cls_e;

  typedef enum logic [1:0] {PCS_SEQ, PCS_BR, PCS_JMP, PCS_JREG} pc_sel_e;

  typedef enum logic [2:0] {
    BRT_NONE, BRT_EQ, BRT_NE, BRT_LT, BRT_GE, BRT_LTU, BRT_GEU, BRT_RSV
  } br_sel_e;

  typedef enum logic [2:0] {
    OA_REG = 3'd0, OA_PC = 3'd1, OA_PC4 = 3'd2, OA_ZERO = 3'd3, OA_DC = 3'd7
  } op0_sel_e;

  typedef enum logic [2:0] {
    OB_REG, OB_SHAMT, OB_IMM_U, OB_IMM_B, OB_IMM_I, OB_IMM_S, OB_ZERO, OB_DC
  } op1_sel_e;

  typedef enum logic [3:0] {
    AF_ADD, AF_SUB, AF_SLL, AF_SLT, AF_SLTU, AF_XOR, AF_SRL, AF_SRA, AF_OR, AF_AND
  } alu_fn_e;

  typedef enum logic [2:0] {MF_MUL_SS, MF_MUL_SU, MF_MUL_UU, MF_DIV_S, MF_DIV_U} md_fn_e;

  typedef enum logic [1:0] {EX_ALU, EX_MD, EX_DC} ex_sel_e;
  typedef enum logic [1:0] {MO_NONE, MO_LOAD, MO_STORE} mem_op_e;
  typedef enum logic [1:0] {MW_B, MW_H, MW_W} mem_w_e;
  typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_DC} wb_sel_e;

  typedef struct packed {
    pc_sel_e  pc_sel;
    logic     valid;
    logic     jump_en;
    br_sel_e  br_sel;
    op0_sel_e op0_sel;
    op1_sel_e op1_sel;
    alu_fn_e  alu_fn;
    md_fn_e   md_fn;
    logic     md_en;
    logic     md_hi;
    ex_sel_e  ex_sel;
    mem_op_e  mem_op;
    mem_w_e   mem_w;
    logic     mem_uns;
    wb_sel_e  wb_sel;
    logic     rf_wen;
  } ctrl_word_t;

  localparam int CW_W = $bits(ctrl_word_t);

endpackage

// File: rtl/rvdec_classify.sv
module rvdec_classify
  import rvdec_pkg::*;
#(
  parameter bit M_EN = 1'b1
) (
  input  logic [OPC_W-1:0] opc_i,
  input  logic [F3_W-1:0]  f3_i,
  input  logic [F7_W-1:0]  f7_i,
  output inst_cls_e        cls_o
);

  logic shift_f7_ok;
  logic op_base_ok;

  // srai/srli share funct3 5; only 5 also accepts the alternate funct7
  assign shift_f7_ok = (f7_i == F7_BASE) || ((f7_i == F7_ALT) && (f3_i == 3'd5));
  assign op_base_ok  = (f7_i == F7_BASE) ||
                       ((f7_i == F7_ALT) && ((f3_i == 3'd0) || (f3_i == 3'd5)));

  always_comb begin
    cls_o = CL_ILL;
    case (opc_i)
      OPC_LUI:    cls_o = CL_LUI;
      OPC_AUIPC:  cls_o = CL_AUIPC;
      OPC_JAL:    cls_o = CL_JAL;
      OPC_JALR:   if (f3_i == 3'd0) cls_o = CL_JALR;
      OPC_BRANCH: if (f3_i[2:1] != 2'b01) cls_o = CL_BR;
      OPC_LOAD:   if ((f3_i != 3'd3) && (f3_i[2:1] != 2'b11)) cls_o = CL_LD;
      OPC_STORE:  if (!f3_i[2] && (f3_i != 3'd3)) cls_o = CL_ST;
      OPC_OPIMM: begin
        if (f3_i[1:0] == 2'b01) begin
          if (shift_f7_ok) cls_o = CL_SHI;
        end else begin
          cls_o = CL_OPI;
        end
      end
      OPC_OP: begin
        if (op_base_ok) cls_o = CL_OP;
        else if (M_EN && (f7_i == F7_MD)) cls_o = CL_MD;
      end
      default: cls_o = CL_ILL;
    endcase
  end

endmodule

// File: rtl/rvdec_alu_fn.sv
module rvdec_alu_fn
  import rvdec_pkg::*;
(
  input  inst_cls_e       cls_i,
  input  logic [F3_W-1:0] f3_i,
  input  logic            alt_i,
  output alu_fn_e         alu_fn_o
);

  alu_fn_e arith_fn;

  always_comb begin
    case (f3_i)
      3'd0:    arith_fn = (cls_i == CL_OP && alt_i) ? AF_SUB : AF_ADD;
      3'd1:    arith_fn = AF_SLL;
      3'd2:    arith_fn = AF_SLT;
      3'd3:    arith_fn = AF_SLTU;
      3'd4:    arith_fn = AF_XOR;
      3'd5:    arith_fn = alt_i ? AF_SRA : AF_SRL;
      3'd6:    arith_fn = AF_OR;
      default: arith_fn = AF_AND;
    endcase
  end

  always_comb begin
    case (cls_i)
      CL_OPI, CL_SHI, CL_OP: alu_fn_o = arith_fn;
      CL_BR: begin
        if (!f3_i[2])     alu_fn_o = AF_XOR;
        else if (!f3_i[1]) alu_fn_o = AF_SLT;
        else               alu_fn_o = AF_SLTU;
      end
      default: alu_fn_o = AF_ADD;
    endcase
  end

  always_comb begin
    assert_br_cmp_fn_R11: assert ((cls_i != CL_BR) ||
                                  (alu_fn_o inside {AF_XOR, AF_SLT, AF_SLTU}));
  end

endmodule

// File: rtl/rvdec_md_fn.sv
module rvdec_md_fn
  import rvdec_pkg::*;
(
  input  logic [F3_W-1:0] f3_i,
  output md_fn_e          md_fn_o,
  output logic            md_hi_o
);

  // f3[2] splits multiply from divide; low bits pick signedness / half
  always_comb begin
    if (f3_i[2]) begin
      md_fn_o = f3_i[0] ? MF_DIV_U : MF_DIV_S;
      md_hi_o = f3_i[1];
    end else begin
      case (f3_i[1:0])
        2'd2:    md_fn_o = MF_MUL_SU;
        2'd3:    md_fn_o = MF_MUL_UU;
        default: md_fn_o = MF_MUL_SS;
      endcase
      md_hi_o = (f3_i[1:0] != 2'd0);
    end
  end

endmodule

// File: rtl/rv32_ctrl_decoder.sv
module rv32_ctrl_decoder
  import rvdec_pkg::*;
#(
  parameter bit M_EN = 1'b1
) (
  input  logic [ILEN-1:0] inst_i,
  output logic [CW_W-1:0] ctrl_o,
  output logic            rs1_en_o,
  output logic            rs2_en_o,
  output logic [RA_W-1:0] rf_waddr_o
);

  logic [OPC_W-1:0] opc;
  logic [F3_W-1:0]  f3;
  logic [F7_W-1:0]  f7;
  logic [RA_W-1:0]  rd;
  logic             unused_src_bits;

  inst_cls_e  cls;
  alu_fn_e    alu_fn;
  md_fn_e     md_fn;
  logic       md_hi;
  br_sel_e    br_sel;
  ctrl_word_t cw;

  assign opc = inst_i[OPC_W-1:0];
  assign rd  = inst_i[OPC_W+RA_W-1:OPC_W];
  assign f3  = inst_i[OPC_W+RA_W+F3_W-1:OPC_W+RA_W];
  assign f7  = inst_i[ILEN-1:ILEN-F7_W];
  assign unused_src_bits = ^inst_i[ILEN-F7_W-1:OPC_W+RA_W+F3_W];

  rvdec_classify #(.M_EN(M_EN)) u_classify (
    .opc_i (opc),
    .f3_i  (f3),
    .f7_i  (f7),
    .cls_o (cls)
  );

  rvdec_alu_fn u_alu_fn (
    .cls_i    (cls),
    .f3_i     (f3),
    .alt_i    (f7[5]),
    .alu_fn_o (alu_fn)
  );

  generate
    if (M_EN) begin : g_md
      rvdec_md_fn u_md_fn (
        .f3_i    (f3),
        .md_fn_o (md_fn),
        .md_hi_o (md_hi)
      );
    end else begin : g_no_md
      assign md_fn = MF_MUL_SS;
      assign md_hi = 1'b0;
    end
  endgenerate

  always_comb begin
    case (f3)
      3'd0:    br_sel = BRT_EQ;
      3'd1:    br_sel = BRT_NE;
      3'd4:    br_sel = BRT_LT;
      3'd5:    br_sel = BRT_GE;
      3'd6:    br_sel = BRT_LTU;
      3'd7:    br_sel = BRT_GEU;
      default: br_sel = BRT_NONE;
    endcase
  end

  always_comb begin
    cw       = '0;
    rs1_en_o = 1'b0;
    rs2_en_o = 1'b0;
    if (cls != CL_ILL) begin
      cw.valid  = 1'b1;
      cw.alu_fn = alu_fn;
    end
    case (cls)
      CL_LUI: begin
        cw.op0_sel = OA_ZERO;
        cw.op1_sel = OB_IMM_U;
        cw.rf_wen  = 1'b1;
      end
      CL_AUIPC: begin
        cw.op0_sel = OA_PC;
        cw.op1_sel = OB_IMM_U;
        cw.rf_wen  = 1'b1;
      end
      CL_JAL, CL_JALR: begin
        // link = PC+4 + 0; target is formed by next-PC logic
        cw.pc_sel  = (cls == CL_JAL) ? PCS_JMP : PCS_JREG;
        cw.jump_en = 1'b1;
        cw.op0_sel = OA_PC4;
        cw.op1_sel = OB_ZERO;
        cw.rf_wen  = 1'b1;
        rs1_en_o   = (cls == CL_JALR);
      end
      CL_BR: begin
        cw.pc_sel  = PCS_BR;
        cw.br_sel  = br_sel;
        cw.op0_sel = OA_REG;
        cw.op1_sel = OB_REG;
        cw.ex_sel  = EX_DC;
        cw.wb_sel  = WB_DC;
        rs1_en_o   = 1'b1;
        rs2_en_o   = 1'b1;
      end
      CL_LD: begin
        cw.op0_sel = OA_REG;
        cw.op1_sel = OB_IMM_I;
        cw.mem_op  = MO_LOAD;
        cw.mem_w   = mem_w_e'(f3[1:0]);
        cw.mem_uns = f3[2];
        cw.wb_sel  = WB_MEM;
        cw.rf_wen  = 1'b1;
        rs1_en_o   = 1'b1;
      end
      CL_ST: begin
        cw.op0_sel = OA_REG;
        cw.op1_sel = OB_IMM_S;
        cw.mem_op  = MO_STORE;
        cw.mem_w   = mem_w_e'(f3[1:0]);
        cw.wb_sel  = WB_DC;
        rs1_en_o   = 1'b1;
        rs2_en_o   = 1'b1;
      end
      CL_OPI, CL_SHI: begin
        cw.op0_sel = OA_REG;
        cw.op1_sel = (cls == CL_SHI) ? OB_SHAMT : OB_IMM_I;
        cw.rf_wen  = 1'b1;
        rs1_en_o   = 1'b1;
      end
      CL_OP, CL_MD: begin
        cw.op0_sel = OA_REG;
        cw.op1_sel = OB_REG;
        cw.rf_wen  = 1'b1;
        rs1_en_o   = 1'b1;
        rs2_en_o   = 1'b1;
        if (cls == CL_MD) begin
          cw.md_fn  = md_fn;
          cw.md_en  = 1'b1;
          cw.md_hi  = md_hi;
          cw.ex_sel = EX_MD;
        end
      end
      default: ;
    endcase
  end

  assign ctrl_o     = cw;
  assign rf_waddr_o = cw.rf_wen ? rd : '0;

  always_comb begin
    assert_idle_word_R2: assert (cw.valid || ((cw == '0) && !rs1_en_o && !rs2_en_o));
    assert_md_path_R12: assert (cw.md_en == (cw.ex_sel == EX_MD));
    assert_store_nowb_R8: assert ((cw.mem_op != MO_STORE) || (!cw.rf_wen && rs2_en_o));
    assert_branch_quiet_R11: assert ((cw.br_sel == BRT_NONE) ||
                                     ((cw.pc_sel == PCS_BR) && !cw.rf_wen &&
                                      (cw.mem_op == MO_NONE) && !cw.jump_en));
    assert_jump_link_R9: assert (!cw.jump_en ||
                                 ((cw.op0_sel == OA_PC4) && cw.rf_wen &&
                                  (cw.pc_sel inside {PCS_JMP, PCS_JREG})));
    assert_waddr_gate_R13: assert (cw.rf_wen || (rf_waddr_o == '0));
  end

endmodule

// File: tb/tb_rv32_ctrl_decoder.sv
module tb_rv32_ctrl_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYC = 150000;
  localparam int RAND_VEC = 3000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] inst = 32'h0;
  logic [31:0] ctrl;
  logic        rs1_en, rs2_en;
  logic [4:0]  waddr;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rv32_ctrl_decoder dut (
    .inst_i     (inst),
    .ctrl_o     (ctrl),
    .rs1_en_o   (rs1_en),
    .rs2_en_o   (rs2_en),
    .rf_waddr_o (waddr)
  );

  function automatic int arith_code(input int f3);
    case (f3)
      0: return 0; 1: return 2; 2: return 3; 3: return 4;
      4: return 5; 5: return 6; 6: return 8; default: return 9;
    endcase
  endfunction

  // Behavioural reference built straight from the requirement text
  function automatic void model(input logic [31:0] in, output logic [31:0] cw,
                                output logic r1, output logic r2,
                                output logic [4:0] wa, output string req);
    int opc = int'(in[6:0]);
    int f3  = int'(in[14:12]);
    int f7  = int'(in[31:25]);
    int pc = 0, v = 0, j = 0, br = 0, o0 = 0, o1 = 0, alu = 0, mf = 0;
    int men = 0, mhi = 0, ex = 0, mo = 0, mw = 0, mu = 0, wb = 0, we = 0;
    r1 = 0; r2 = 0; req = "R1 R2";
    case (opc)
      'h37: begin v = 1; o0 = 3; o1 = 2; we = 1; req = "R1 R6"; end
      'h17: begin v = 1; o0 = 1; o1 = 2; we = 1; req = "R1 R6"; end
      'h6f: begin v = 1; pc = 2; j = 1; o0 = 2; o1 = 6; we = 1; req = "R1 R9"; end
      'h67: if (f3 == 0) begin
        v = 1; pc = 3; j = 1; o0 = 2; o1 = 6; we = 1; r1 = 1; req = "R1 R10";
      end
      'h63: if (f3 != 2 && f3 != 3) begin
        v = 1; pc = 1; r1 = 1; r2 = 1; ex = 2; wb = 2; req = "R1 R11";
        case (f3)
          0: br = 1; 1: br = 2; 4: br = 3; 5: br = 4; 6: br = 5; default: br = 6;
        endcase
        alu = (f3 < 2) ? 5 : (f3 < 6) ? 3 : 4;
      end
      'h03: if (f3 == 0 || f3 == 1 || f3 == 2 || f3 == 4 || f3 == 5) begin
        v = 1; o1 = 4; mo = 1; mw = f3 % 4; mu = f3 / 4; wb = 1; we = 1; r1 = 1;
        req = "R1 R7";
      end
      'h23: if (f3 < 3) begin
        v = 1; o1 = 5; mo = 2; mw = f3; wb = 2; r1 = 1; r2 = 1; req = "R1 R8";
      end
      'h13: begin
        if (f3 == 1) begin
          if (f7 == 0) begin v = 1; o1 = 1; alu = 2; we = 1; r1 = 1; req = "R1 R4"; end
        end else if (f3 == 5) begin
          if (f7 == 0 || f7 == 'h20) begin
            v = 1; o1 = 1; alu = (f7 == 0) ? 6 : 7; we = 1; r1 = 1; req = "R1 R4";
          end
        end else begin
          v = 1; o1 = 4; alu = arith_code(f3); we = 1; r1 = 1; req = "R1 R3";
        end
      end
      'h33: begin
        if (f7 == 0) begin
          v = 1; alu = arith_code(f3); we = 1; r1 = 1; r2 = 1; req = "R1 R5";
        end else if (f7 == 'h20 && (f3 == 0 || f3 == 5)) begin
          v = 1; alu = (f3 == 0) ? 1 : 7; we = 1; r1 = 1; r2 = 1; req = "R1 R5";
        end else if (f7 == 1) begin
          v = 1; men = 1; ex = 1; we = 1; r1 = 1; r2 = 1; req = "R1 R12";
          case (f3)
            0: begin mf = 0; mhi = 0; end
            1: begin mf = 0; mhi = 1; end
            2: begin mf = 1; mhi = 1; end
            3: begin mf = 2; mhi = 1; end
            4: begin mf = 3; mhi = 0; end
            5: begin mf = 4; mhi = 0; end
            6: begin mf = 3; mhi = 1; end
            default: begin mf = 4; mhi = 1; end
          endcase
        end
      end
      default: ;
    endcase
    cw = {2'(pc), 1'(v), 1'(j), 3'(br), 3'(o0), 3'(o1), 4'(alu), 3'(mf),
          1'(men), 1'(mhi), 2'(ex), 2'(mo), 2'(mw), 1'(mu), 2'(wb), 1'(we)};
    wa = (we != 0) ? in[11:7] : 5'd0;
  endfunction

  task automatic check_now(input logic [31:0] in);
    logic [31:0] e_cw;
    logic e_r1, e_r2;
    logic [4:0] e_wa;
    string req;
    model(in, e_cw, e_r1, e_r2, e_wa, req);
    total++;
    if ({ctrl, rs1_en, rs2_en} !== {e_cw, e_r1, e_r2}) begin
      bad++;
      $display("FAIL %s inst=%h ctrl/rs1/rs2 got %h/%b/%b exp %h/%b/%b",
               req, in, ctrl, rs1_en, rs2_en, e_cw, e_r1, e_r2);
    end
    total++;
    if (waddr !== e_wa) begin
      bad++;
      $display("FAIL R13 inst=%h waddr got %0d exp %0d", in, waddr, e_wa);
    end
  endtask

  task automatic step(input logic [31:0] in);
    @(posedge clk);
    inst = in;
    @(negedge clk);
    check_now(in);
  endtask

  initial begin
    int opcs[14] = '{'h37, 'h17, 'h6f, 'h67, 'h63, 'h03, 'h23, 'h13, 'h33,
                     'h0f, 'h73, 'h00, 'h7f, 'h3b};
    int f7s[6] = '{'h00, 'h20, 'h01, 'h7f, 'h02, 'h21};
    // reset state: instruction word of zero is unrecognised (R1, R2)
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_now(32'h0);
    rst_n = 1'b1;

    // ignored-bit case: addi with bit 30 set must remain add (R3)
    step({7'h20, 5'd3, 5'd4, 3'd0, 5'd9, 7'h13});
    // rd=0 with write enabled still reports 0; store rd field gated (R13)
    step({7'h00, 5'd1, 5'd2, 3'd2, 5'd17, 7'h23});
    step({7'h01, 5'd1, 5'd2, 3'd7, 5'd0, 7'h33});

    for (int oi = 0; oi < 14; oi++) begin
      for (int f3 = 0; f3 < 8; f3++) begin
        for (int fi = 0; fi < 6; fi++) begin
          logic [31:0] w;
          w = $urandom;
          w[6:0]   = 7'(opcs[oi]);
          w[14:12] = 3'(f3);
          w[31:25] = 7'(f7s[fi]);
          step(w);
        end
      end
    end

    for (int k = 0; k < RAND_VEC; k++) begin
      logic [31:0] w;
      w = $urandom;
      if (k % 2 == 0) w[6:0] = 7'(opcs[k % 9]);
      step(w);
    end

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired got running exp done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule